// File: doc/BRIEF.md
# Hierarchical Maskable Interrupt Aggregator

This block gathers interrupt sources for a USB on-the-go bridge and drives one interrupt line towards the host processor. Sources sit in four 32-bit groups, each with a pending word and a mask word: a top-level group, a USB-core group, a DMA group and a GPIO group. Software sets pending bits through a SET address and removes them through a CLEAR address. Level-following event inputs from the USB core also feed the top-level group. The unmasked pending bits of the USB-core and DMA groups fold into dedicated summary bits of the top-level word. The GPIO group is stored and readable, but it does not reach the output.

The host line is a registered reduction of the unmasked top-level bits. A configuration bit selects whether the line goes high when any bit is pending, or when none is pending. A power-up gate holds the line low for a programmable number of cycles each time the supply input turns on.

Top module: `irq_aggregator`

## Requirements
- R1: A write to a group's SET address (offset 1) ORs the written data into its pending word. A write to its CLEAR address (offset 2) removes every bit that is one in the data. Both take effect at the clock edge that accepts the write.
- R2: After reset, the top-level mask is all ones. All pending words, the three sub-group masks and the config word are zero, and host_irq is 0.
- R3: Top-level bit 9 is one exactly when the USB-core group has an unmasked pending bit in bits 15..0. Top-level bit 8 is one exactly when the group has one in bits 31..16.
- R4: Top-level bit 24 is one exactly when the DMA group has any unmasked pending bit.
- R5: With config bit 17 set, host_irq is the OR of the unmasked top-level bits ANDed with the power gate. With bit 17 clear, it is the NOR of those bits ANDed with the gate.
- R6: The power gate resets to 0. A 0-to-1 change of power_on drops the gate at once. The gate rises PWR_DLY edges later if power_on stays high all that time. If power_on falls during the wait, the wait is abandoned and the gate stays 0 until the next rise. A fall of power_on does not by itself change the gate.
- R7: Word address bits [3:2] pick the group when bit 4 is 0: 0 top, 1 USB core, 2 DMA, 3 GPIO. Offsets 0, 1 and 2 read the group's pending word and offset 3 reads its mask. Address 0x10 is the config word. Every other address reads 0.
- R8: A rising edge on core_evt[n] sets top-level bit n, and a falling edge clears it. A software clear made while the input stays high is kept.
- R9: The GPIO group's pending and mask words can be written and read back, and they never affect host_irq.
- R10: host_irq is registered. It reflects a register change one clock edge after the edge that made the change.
- R11: Top-level bits 8, 9 and 24 follow only their sub-groups. SET and CLEAR writes aimed at these bits in the top-level group have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| power_on | input | 1 | Supply-on indication that starts the power gate |
| core_evt | input | CORE_EVT_N | Level event lines from the USB core, mapped to top-level bits 0 and up |
| host_irq | output | 1 | Registered interrupt line to the host |

## Verification
A wrong pending or mask bit shows up at bus_rdata as soon as the affected address is read in the cycle after the write. It also shows at host_irq one edge later, once the polarity and the masks leave that bit as the only contributor. A wrong summary bit shows in the top-level readback as soon as a sub-group write or mask change should have moved it. A wrong power-gate count moves the edge where host_irq first rises after power-up. The bench therefore samples that line both just before and just after the expected cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int NGRP   = 4;

  localparam int GRP_TOP  = 0;
  localparam int GRP_CORE = 1;
  localparam int GRP_DMA  = 2;
  localparam int GRP_GPIO = 3;

  localparam logic [1:0] SEL_SET  = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 5'h10;

  localparam int BIT_CORE_RX = 8;
  localparam int BIT_CORE_TX = 9;
  localparam int BIT_DMA     = 24;
  localparam int POL_BIT     = 17;

  localparam logic [DATA_W-1:0] SUMMARY_BITS =
    (DATA_W'(1) << BIT_CORE_RX) | (DATA_W'(1) << BIT_CORE_TX) | (DATA_W'(1) << BIT_DMA);
endpackage

// File: rtl/irq_group.sv
module irq_group #(
  parameter int               W        = 32,
  parameter logic [W-1:0]     MASK_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask
);
  logic [W-1:0] pend_d, mask_d;
  logic [W-1:0] sw_set, sw_clr;
  logic         pend_en;

  always_comb begin
    sw_set  = set_we ? wdata : '0;
    sw_clr  = clr_we ? wdata : '0;
    pend_d  = (((pend | sw_set) & ~sw_clr) | hw_set) & ~hw_clr;
    pend_en = set_we | clr_we | (|hw_set) | (|hw_clr);
    mask_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= MASK_RST;
    end else begin
      if (pend_en) pend <= pend_d;
      if (mask_we) mask <= mask_d;
    end
  end
endmodule

// File: rtl/irq_evt_edge.sv
module irq_evt_edge #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  output logic [W-1:0] rise_bits,
  output logic [W-1:0] fall_bits
);
  logic [N-1:0] evt_q;

  always_comb begin
    rise_bits = W'(evt & ~evt_q);
    fall_bits = W'(~evt & evt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt;
  end
endmodule

// File: rtl/irq_pwr_gate.sv
module irq_pwr_gate #(
  parameter int PWR_DLY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_on,
  output logic gate
);
  localparam int CNT_W = $clog2(PWR_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PWR_DLY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             pwr_q, busy, gate_d, busy_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             rise;

  always_comb begin
    rise   = power_on & ~pwr_q;
    gate_d = gate;
    busy_d = busy;
    cnt_d  = cnt;
    if (rise) begin
      gate_d = 1'b0;
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy && !power_on) begin
      busy_d = 1'b0;
    end else if (busy) begin
      if (cnt == CNT_ONE) begin
        gate_d = 1'b1;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
      gate  <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      pwr_q <= power_on;
      gate  <= gate_d;
      busy  <= busy_d;
      cnt   <= cnt_d;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int PWR_DLY    = 1000,
  parameter int CORE_EVT_N = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  power_on,
  input  logic [CORE_EVT_N-1:0] core_evt,
  output logic                  host_irq
);
  localparam int HALF = DATA_W / 2;

  logic              is_grp;
  logic [1:0]        grp_sel, reg_sel;
  logic [NGRP-1:0]   set_we, clr_we, mask_we;
  logic              cfg_we;
  logic [DATA_W-1:0] pend_a [NGRP];
  logic [DATA_W-1:0] mask_a [NGRP];
  logic [DATA_W-1:0] hws_a  [NGRP];
  logic [DATA_W-1:0] hwc_a  [NGRP];
  logic [DATA_W-1:0] evt_rise, evt_fall;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] top_pend, top_mask, top_un, core_un, dma_pend, dma_un;
  logic              gate, cfg_pol, irq_d;

  always_comb begin
    is_grp  = ~bus_addr[4];
    grp_sel = bus_addr[3:2];
    reg_sel = bus_addr[1:0];
    cfg_we  = bus_we & (bus_addr == ADDR_CFG);
    for (int g = 0; g < NGRP; g++) begin
      set_we[g]  = bus_we & is_grp & (grp_sel == 2'(g)) & (reg_sel == SEL_SET);
      clr_we[g]  = bus_we & is_grp & (grp_sel == 2'(g)) & (reg_sel == SEL_CLR);
      mask_we[g] = bus_we & is_grp & (grp_sel == 2'(g)) & (reg_sel == SEL_MASK);
    end
  end

  irq_evt_edge #(.N(CORE_EVT_N), .W(DATA_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (core_evt),
    .rise_bits(evt_rise),
    .fall_bits(evt_fall)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign hws_a[g] = (g == GRP_TOP) ? evt_rise : '0;
    assign hwc_a[g] = (g == GRP_TOP) ? evt_fall : '0;
    irq_group #(
      .W       (DATA_W),
      .MASK_RST((g == GRP_TOP) ? {DATA_W{1'b1}} : {DATA_W{1'b0}})
    ) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we[g]),
      .clr_we (clr_we[g]),
      .mask_we(mask_we[g]),
      .wdata  (bus_wdata),
      .hw_set (hws_a[g]),
      .hw_clr (hwc_a[g]),
      .pend   (pend_a[g]),
      .mask   (mask_a[g])
    );
  end

  irq_pwr_gate #(.PWR_DLY(PWR_DLY)) u_pwr (
    .clk     (clk),
    .rst_n   (rst_n),
    .power_on(power_on),
    .gate    (gate)
  );

  // summary folding of the sub-groups into the top-level word
  always_comb begin
    core_un  = pend_a[GRP_CORE] & ~mask_a[GRP_CORE];
    dma_pend = pend_a[GRP_DMA];
    dma_un   = dma_pend & ~mask_a[GRP_DMA];
    top_pend = pend_a[GRP_TOP] & ~SUMMARY_BITS;
    top_pend[BIT_CORE_TX] = |core_un[HALF-1:0];
    top_pend[BIT_CORE_RX] = |core_un[DATA_W-1:HALF];
    top_pend[BIT_DMA]     = |dma_un;
    top_mask = mask_a[GRP_TOP];
    top_un   = top_pend & ~top_mask;
    cfg_pol  = cfg_q[POL_BIT];
    irq_d    = gate & (cfg_pol ? (|top_un) : ~(|top_un));
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CFG) begin
      bus_rdata = cfg_q;
    end else if (is_grp) begin
      if (reg_sel == SEL_MASK)
        bus_rdata = mask_a[grp_sel];
      else if (grp_sel == 2'(GRP_TOP))
        bus_rdata = top_pend;
      else
        bus_rdata = pend_a[grp_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      host_irq <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= bus_wdata;
      host_irq <= irq_d;
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              power_on,
  input logic              host_irq,
  input logic [DATA_W-1:0] dma_pend,
  input logic [DATA_W-1:0] top_mask,
  input logic [DATA_W-1:0] top_un,
  input logic              gate,
  input logic              cfg_pol
);
  localparam logic [ADDR_W-1:0] A_DMA_SET  = 5'h09;
  localparam logic [ADDR_W-1:0] A_DMA_CLR  = 5'h0A;
  localparam logic [ADDR_W-1:0] A_TOP_MASK = 5'h03;

  assert_set_or_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DMA_SET) |=> ((dma_pend & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DMA_CLR) |=> ((dma_pend & $past(bus_wdata)) == '0));

  assert_gate_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_on) |=> !gate);

  assert_gated_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !host_irq);

  assert_pol_high_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pol && top_un == '0) |=> !host_irq);

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_TOP_MASK) |=> $stable(top_mask));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .power_on (power_on),
  .host_irq (host_irq),
  .dma_pend (dma_pend),
  .top_mask (top_mask),
  .top_un   (top_un),
  .gate     (gate),
  .cfg_pol  (cfg_pol)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int DLY = 20;
  localparam int EVN = 8;

  localparam logic [4:0] A_TOP_PEND = 5'h00, A_TOP_SET = 5'h01, A_TOP_CLR = 5'h02, A_TOP_MASK = 5'h03;
  localparam logic [4:0] A_CORE_SET = 5'h05, A_CORE_CLR = 5'h06, A_CORE_MASK = 5'h07;
  localparam logic [4:0] A_DMA_PEND = 5'h08, A_DMA_SET = 5'h09, A_DMA_CLR = 5'h0A, A_DMA_MASK = 5'h0B;
  localparam logic [4:0] A_GPIO_PEND = 5'h0C, A_GPIO_SET = 5'h0D, A_GPIO_MASK = 5'h0F;
  localparam logic [4:0] A_CFG = 5'h10;
  localparam logic [31:0] POL = 32'h0002_0000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_we;
  logic [4:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            power_on;
  logic [EVN-1:0]  core_evt;
  logic            host_irq;

  int vec = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_aggregator #(.PWR_DLY(DLY), .CORE_EVT_N(EVN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .power_on(power_on),
    .core_evt(core_evt), .host_irq(host_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    power_on = 1'b0; core_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk);
    power_on = 1'b1;
    repeat (DLY + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(A_TOP_MASK, d);  chk("R2 top mask", d, 32'hFFFF_FFFF);
    rd(A_TOP_PEND, d);  chk("R2 top pend", d, 32'h0);
    rd(A_CORE_MASK, d); chk("R2 core mask", d, 32'h0);
    rd(A_DMA_MASK, d);  chk("R2 dma mask", d, 32'h0);
    rd(A_CFG, d);       chk("R2 cfg", d, 32'h0);
    chk("R2 irq low", 32'(host_irq), 32'h0);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    do_reset();
    wr(A_TOP_SET, 32'h0000_0005);
    rd(A_TOP_PEND, d); chk("R1 set", d, 32'h5);
    wr(A_TOP_SET, 32'h8000_0000);
    rd(A_TOP_PEND, d); chk("R1 set or", d, 32'h8000_0005);
    wr(A_TOP_CLR, 32'h8000_0004);
    rd(A_TOP_PEND, d); chk("R1 clear", d, 32'h1);
    wr(A_DMA_SET, 32'h00F0_000F);
    wr(A_DMA_CLR, 32'h0030_0003);
    rd(A_DMA_PEND, d); chk("R1 dma clear", d, 32'h00C0_000C);
  endtask

  task automatic t_core_summary();
    logic [31:0] d;
    do_reset();
    power_up();
    wr(A_CFG, POL);
    wr(A_TOP_MASK, ~(32'h1 << 9));
    wr(A_CORE_SET, 32'h0000_0001);
    rd(A_TOP_PEND, d); chk("R3 tx bit", d, 32'h0000_0200);
    @(negedge clk);
    chk("R3 tx irq", 32'(host_irq), 32'h1);
    wr(A_CORE_MASK, 32'h0000_0001);
    rd(A_TOP_PEND, d); chk("R3 tx masked", d, 32'h0);
    @(negedge clk);
    chk("R3 tx irq off", 32'(host_irq), 32'h0);
    wr(A_CORE_SET, 32'h0001_0000);
    rd(A_TOP_PEND, d); chk("R3 rx bit", d, 32'h0000_0100);
    @(negedge clk);
    chk("R3 rx top-masked", 32'(host_irq), 32'h0);
    wr(A_CORE_CLR, 32'h0001_0000);
    rd(A_TOP_PEND, d); chk("R3 rx cleared", d, 32'h0);
  endtask

  task automatic t_dma_summary();
    logic [31:0] d;
    do_reset();
    wr(A_DMA_SET, 32'h8000_0000);
    rd(A_TOP_PEND, d); chk("R4 dma bit", d, 32'h0100_0000);
    wr(A_DMA_MASK, 32'hFFFF_FFFF);
    rd(A_TOP_PEND, d); chk("R4 dma masked", d, 32'h0);
    rd(A_DMA_PEND, d); chk("R4 dma pend kept", d, 32'h8000_0000);
  endtask

  task automatic t_polarity();
    do_reset();
    power_up();
    chk("R5 nor idle masked", 32'(host_irq), 32'h1);
    wr(A_TOP_MASK, 32'h0);
    wr(A_TOP_SET, 32'h1);
    @(negedge clk);
    chk("R5 nor pending", 32'(host_irq), 32'h0);
    wr(A_CFG, POL);
    @(negedge clk);
    chk("R5 or pending", 32'(host_irq), 32'h1);
    wr(A_TOP_CLR, 32'h1);
    @(negedge clk);
    chk("R5 or idle", 32'(host_irq), 32'h0);
  endtask

  task automatic t_power();
    do_reset();
    @(negedge clk);
    power_on = 1'b1;
    repeat (DLY + 1) @(negedge clk);
    chk("R6 still gated", 32'(host_irq), 32'h0);
    @(negedge clk);
    chk("R6 gate open", 32'(host_irq), 32'h1);
    power_on = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 fall keeps gate", 32'(host_irq), 32'h1);
    power_on = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 re-rise drops", 32'(host_irq), 32'h0);
    repeat (5) @(negedge clk);
    power_on = 1'b0;
    repeat (DLY * 2) @(negedge clk);
    chk("R6 abort wait", 32'(host_irq), 32'h0);
    power_on = 1'b1;
    repeat (DLY + 2) @(negedge clk);
    chk("R6 reopen", 32'(host_irq), 32'h1);
  endtask

  task automatic t_read_map();
    logic [31:0] d;
    do_reset();
    wr(A_CFG, 32'h0002_00A5);
    rd(A_CFG, d); chk("R7 cfg read", d, 32'h0002_00A5);
    wr(A_DMA_SET, 32'h0000_1234);
    rd(A_DMA_SET, d); chk("R7 set addr reads pend", d, 32'h0000_1234);
    rd(A_DMA_CLR, d); chk("R7 clr addr reads pend", d, 32'h0000_1234);
    rd(5'h11, d); chk("R7 unmapped", d, 32'h0);
  endtask

  task automatic t_core_evt();
    logic [31:0] d;
    do_reset();
    @(negedge clk); core_evt[3] = 1'b1;
    @(negedge clk);
    rd(A_TOP_PEND, d); chk("R8 rise sets", d, 32'h8);
    wr(A_TOP_CLR, 32'h8);
    @(negedge clk);
    rd(A_TOP_PEND, d); chk("R8 sw clear kept", d, 32'h0);
    core_evt[3] = 1'b0; core_evt[5] = 1'b1;
    @(negedge clk);
    rd(A_TOP_PEND, d); chk("R8 second rise", d, 32'h20);
    core_evt[5] = 1'b0;
    @(negedge clk);
    rd(A_TOP_PEND, d); chk("R8 fall clears", d, 32'h0);
  endtask

  task automatic t_gpio();
    logic [31:0] d;
    do_reset();
    power_up();
    wr(A_CFG, POL);
    wr(A_TOP_MASK, 32'h0);
    wr(A_GPIO_SET, 32'h0000_00FF);
    wr(A_GPIO_MASK, 32'h0000_000F);
    rd(A_GPIO_PEND, d); chk("R9 gpio pend", d, 32'hFF);
    rd(A_GPIO_MASK, d); chk("R9 gpio mask", d, 32'hF);
    @(negedge clk);
    chk("R9 no irq", 32'(host_irq), 32'h0);
  endtask

  task automatic t_latency();
    do_reset();
    power_up();
    wr(A_CFG, POL);
    wr(A_TOP_MASK, 32'h0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_TOP_SET; bus_wdata = 32'h2;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R10 not yet", 32'(host_irq), 32'h0);
    @(negedge clk);
    chk("R10 one edge later", 32'(host_irq), 32'h1);
  endtask

  task automatic t_summary_ro();
    logic [31:0] d;
    do_reset();
    wr(A_TOP_SET, 32'h0100_0300);
    rd(A_TOP_PEND, d); chk("R11 set ignored", d, 32'h0);
    wr(A_CORE_SET, 32'h0000_0010);
    wr(A_TOP_CLR, 32'h0000_0200);
    rd(A_TOP_PEND, d); chk("R11 clear ignored", d, 32'h0000_0200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    power_on = 1'b0; core_evt = '0;
    t_reset();
    t_set_clear();
    t_core_summary();
    t_dma_summary();
    t_polarity();
    t_power();
    t_read_map();
    t_core_evt();
    t_gpio();
    t_latency();
    t_summary_ro();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule